// File: doc/BRIEF.md
# Mode-Dependent Peripheral Clock Prescaler

This block produces one-cycle clock-enable strobes for a set of peripheral reference rates, all from a single core clock. It never creates a clock net. Downstream logic runs on the core clock and acts only in cycles where its strobe is high.

A mode input picks one of two operating cases. In the PLL case the core runs from a multiplied oscillator, and the references use large fixed ratios. In the external-clock case the core runs from a fast external source, and the references use a smaller set of ratios. One further select bit picks between two timer reference ratios, and it matters only in the external case.

Below the references sit child dividers. These count parent strobes rather than core cycles:
- a serial-peripheral clock with a 2-bit lookup code;
- two timer clocks, each with a 1-bit lookup code;
- a UART reference at one tenth of the bus strobe.

Whenever the mode or a select changes, the counters it affects restart. Their next strobe then falls one full new period later.

Top module: `clkpre_prescaler`

## Requirements
- R1: Every strobe is high for single cycles only. The timer, serial and PWM reference strobes are never high in two consecutive cycles.
- R2: With `ext_mode`=0 (PLL case), strobe periods in core cycles are: timer reference 144, serial reference 576, PWM 768, bus 2.
- R3: With `ext_mode`=1 (external case), strobe periods are: serial reference 96, PWM 128, bus 1 (high in every cycle).
- R4: In the external case the timer reference period is 26 when `tmr_alt`=1 and 24 when `tmr_alt`=0. In the PLL case `tmr_alt` has no effect: the period stays 144 and the phase is not disturbed.
- R5: The serial child strobe `spi_stb` fires once per N serial reference strobes. `spi_sel` code 0 gives N=32, code 1 gives 8, code 2 gives 2 and code 3 gives 1.
- R6: Timer child strobe i (`tmr_stb[i]`) fires once per N timer reference strobes. N=256 when `tmr_sel[i]`=0 and N=1 when `tmr_sel[i]`=1. Each timer is independent of the other.
- R7: `uart_stb` fires once per 10 bus strobes. Its period is therefore 20 cycles in the PLL case and 10 in the external case.
- R8: A change of `ext_mode` restarts every counter. A change of `tmr_alt` in the external case restarts the timer chain. A change of `spi_sel` or `tmr_sel[i]` restarts that child. In the cycle the change is seen, the affected strobes are low. A restarted ratio-N root strobe is next high N edges later.
- R9: A divide-by-1 child selection makes the child strobe equal to its parent strobe in every cycle.
- R10: While `rst_n` is low (sampled synchronously), all counters clear and every strobe is low. After release between edges, a ratio-N root strobe is first high N-1 edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_mode | input | 1 | 0 = PLL case, 1 = external-clock case |
| tmr_alt | input | 1 | Timer reference ratio select, external case only |
| spi_sel | input | 2 | Serial child divider code |
| tmr_sel | input | N_TMR | Timer child divider code, one bit per timer |
| tmr_ref_stb | output | 1 | Timer reference strobe |
| spi_ref_stb | output | 1 | Serial reference strobe |
| pwm_stb | output | 1 | PWM reference strobe |
| bus_stb | output | 1 | Bus-rate strobe |
| spi_stb | output | 1 | Serial child strobe |
| tmr_stb | output | N_TMR | Timer child strobes |
| uart_stb | output | 1 | UART reference strobe |

## Verification
The assertions assume that the mode and select inputs change only between clock edges and then hold steady until at least the next edge. The back-to-back and divide-by-1 properties also assume that any change in a divider's ratio arrives together with a restart of that divider; the change detector provides this. The bench drives every input one nanosecond after a rising edge and holds it for whole cycles, so each change is seen at exactly one edge.

// File: rtl/clkpre_pkg.sv
// clkpre_pkg: shared types and child-divider lookup functions for the
// peripheral strobe prescaler. Assumes code widths fixed by the interface.
package clkpre_pkg;

    typedef enum logic {
        CLK_MODE_PLL = 1'b0,
        CLK_MODE_EXT = 1'b1
    } clk_mode_e;

    // Serial child: irregular 2-bit code to division ratio.
    function automatic int unsigned spi_child_div(input logic [1:0] code);
        case (code)
            2'd0:    return 32;
            2'd1:    return 8;
            2'd2:    return 2;
            default: return 1;
        endcase
    endfunction

    // Timer child: 1-bit code, clear selects the long ratio.
    function automatic int unsigned tmr_child_div(input logic code);
        return code ? 1 : 256;
    endfunction

endpackage

// File: rtl/clkpre_strobe_div.sv
// clkpre_strobe_div: counts enable pulses and emits a one-cycle strobe on
// every ratio_m1+1'th enable. Ratio 1 passes the enable straight through.
// Assumes any change of ratio_m1 is accompanied by clr in the same cycle.
module clkpre_strobe_div #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [CNT_W-1:0] ratio_m1,
    output logic             stb
);

    logic [CNT_W-1:0] cnt;
    logic             at_end;

    // Detect the last count of the current period.
    always_comb at_end = (cnt >= ratio_m1);

    // Strobe only on a counted enable outside reset and restart.
    always_comb stb = en && at_end && !clr && rst_n;

    // Advance on each enable, wrap at period end, restart on clr or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= at_end ? '0 : cnt + 1'b1;
        end
    end

    // R1: a divider slower than 1 never strobes two cycles running.
    assert_no_back_to_back_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && ratio_m1 != '0) |=> (!stb || ratio_m1 == '0));

endmodule

// File: rtl/clkpre_ratio_sel.sv
// clkpre_ratio_sel: maps mode and select inputs to the terminal counts
// (ratio minus one) of every root and child divider. Purely combinational.
module clkpre_ratio_sel
    import clkpre_pkg::*;
#(
    parameter int unsigned CNT_W             = 10,
    parameter int unsigned N_TMR             = 2,
    parameter int unsigned PLL_TREF_DIV      = 144,
    parameter int unsigned PLL_SPI_DIV       = 576,
    parameter int unsigned PLL_PWM_DIV       = 768,
    parameter int unsigned PLL_BUS_DIV       = 2,
    parameter int unsigned EXT_TREF_DIV      = 24,
    parameter int unsigned EXT_TREF_ALT_DIV  = 26,
    parameter int unsigned EXT_SPI_DIV       = 96,
    parameter int unsigned EXT_PWM_DIV       = 128,
    parameter int unsigned EXT_BUS_DIV       = 1,
    parameter int unsigned UART_DIV          = 10
) (
    input  clk_mode_e        mode,
    input  logic             tmr_alt,
    input  logic [1:0]       spi_sel,
    input  logic [N_TMR-1:0] tmr_sel,
    output logic [CNT_W-1:0] tref_m1,
    output logic [CNT_W-1:0] sref_m1,
    output logic [CNT_W-1:0] pwm_m1,
    output logic [CNT_W-1:0] bus_m1,
    output logic [CNT_W-1:0] spi_m1,
    output logic [CNT_W-1:0] uart_m1,
    output logic [CNT_W-1:0] tmr_m1 [N_TMR]
);

    localparam logic [CNT_W-1:0] UART_M1 = CNT_W'(UART_DIV - 1);

    // Root ratios follow the clock mode; the alt bit matters only externally.
    always_comb begin
        if (mode == CLK_MODE_EXT) begin
            tref_m1 = tmr_alt ? CNT_W'(EXT_TREF_ALT_DIV - 1) : CNT_W'(EXT_TREF_DIV - 1);
            sref_m1 = CNT_W'(EXT_SPI_DIV - 1);
            pwm_m1  = CNT_W'(EXT_PWM_DIV - 1);
            bus_m1  = CNT_W'(EXT_BUS_DIV - 1);
        end else begin
            tref_m1 = CNT_W'(PLL_TREF_DIV - 1);
            sref_m1 = CNT_W'(PLL_SPI_DIV - 1);
            pwm_m1  = CNT_W'(PLL_PWM_DIV - 1);
            bus_m1  = CNT_W'(PLL_BUS_DIV - 1);
        end
    end

    // Serial and UART child ratios via lookup and constant.
    always_comb begin
        spi_m1  = CNT_W'(spi_child_div(spi_sel) - 1);
        uart_m1 = UART_M1;
    end

    // One lookup per timer child.
    for (genvar gi = 0; gi < N_TMR; gi++) begin : g_tmr_ratio
        always_comb tmr_m1[gi] = CNT_W'(tmr_child_div(tmr_sel[gi]) - 1);
    end

endmodule

// File: rtl/clkpre_change_det.sv
// clkpre_change_det: remembers the configuration seen at the last edge and
// raises restart requests for the counters a configuration change affects.
// Assumes configuration inputs change only between clock edges.
module clkpre_change_det #(
    parameter int unsigned N_TMR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_mode,
    input  logic             tmr_alt,
    input  logic [1:0]       spi_sel,
    input  logic [N_TMR-1:0] tmr_sel,
    output logic             clr_all,
    output logic             clr_tref,
    output logic             clr_spi,
    output logic [N_TMR-1:0] clr_tmr
);

    logic             prev_mode;
    logic             prev_alt;
    logic [1:0]       prev_spi;
    logic [N_TMR-1:0] prev_tmr;
    logic             alt_chg;

    // Capture the configuration each edge; reset adopts the current one.
    always_ff @(posedge clk) begin
        prev_mode <= ext_mode;
        prev_alt  <= tmr_alt;
        prev_spi  <= spi_sel;
        prev_tmr  <= tmr_sel;
    end

    // Alt select only alters the timer ratio in the external case.
    always_comb alt_chg = (tmr_alt != prev_alt) && ext_mode;

    // Fan change flags out to the dependent counters.
    always_comb begin
        clr_all  = rst_n && (ext_mode != prev_mode);
        clr_tref = clr_all || (rst_n && alt_chg);
        clr_spi  = clr_all || (rst_n && (spi_sel != prev_spi));
        for (int i = 0; i < int'(N_TMR); i++) begin
            clr_tmr[i] = clr_tref || (rst_n && (tmr_sel[i] != prev_tmr[i]));
        end
    end

    // R8: a mode change always restarts the timer chain as well.
    assert_mode_clears_timer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode != $past(ext_mode)) |-> (clr_tref && clr_spi && (&clr_tmr)));

endmodule

// File: rtl/clkpre_prescaler.sv
// clkpre_prescaler: top of the peripheral strobe prescaler. Four root
// dividers run from the core clock, four child dividers count root strobes.
// Assumes static selects that change only between edges.
module clkpre_prescaler
    import clkpre_pkg::*;
#(
    parameter int unsigned CNT_W             = 10,
    parameter int unsigned N_TMR             = 2,
    parameter int unsigned PLL_TREF_DIV      = 144,
    parameter int unsigned PLL_SPI_DIV       = 576,
    parameter int unsigned PLL_PWM_DIV       = 768,
    parameter int unsigned PLL_BUS_DIV       = 2,
    parameter int unsigned EXT_TREF_DIV      = 24,
    parameter int unsigned EXT_TREF_ALT_DIV  = 26,
    parameter int unsigned EXT_SPI_DIV       = 96,
    parameter int unsigned EXT_PWM_DIV       = 128,
    parameter int unsigned EXT_BUS_DIV       = 1,
    parameter int unsigned UART_DIV          = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_mode,
    input  logic             tmr_alt,
    input  logic [1:0]       spi_sel,
    input  logic [N_TMR-1:0] tmr_sel,
    output logic             tmr_ref_stb,
    output logic             spi_ref_stb,
    output logic             pwm_stb,
    output logic             bus_stb,
    output logic             spi_stb,
    output logic [N_TMR-1:0] tmr_stb,
    output logic             uart_stb
);

    logic [CNT_W-1:0] tref_m1, sref_m1, pwm_m1, bus_m1, spi_m1, uart_m1;
    logic [CNT_W-1:0] tmr_m1 [N_TMR];
    logic             clr_all, clr_tref, clr_spi;
    logic [N_TMR-1:0] clr_tmr;
    clk_mode_e        mode;

    // Interpret the raw mode pin.
    always_comb mode = clk_mode_e'(ext_mode);

    clkpre_ratio_sel #(
        .CNT_W(CNT_W), .N_TMR(N_TMR),
        .PLL_TREF_DIV(PLL_TREF_DIV), .PLL_SPI_DIV(PLL_SPI_DIV),
        .PLL_PWM_DIV(PLL_PWM_DIV), .PLL_BUS_DIV(PLL_BUS_DIV),
        .EXT_TREF_DIV(EXT_TREF_DIV), .EXT_TREF_ALT_DIV(EXT_TREF_ALT_DIV),
        .EXT_SPI_DIV(EXT_SPI_DIV), .EXT_PWM_DIV(EXT_PWM_DIV),
        .EXT_BUS_DIV(EXT_BUS_DIV), .UART_DIV(UART_DIV)
    ) u_ratio (
        .mode(mode), .tmr_alt(tmr_alt), .spi_sel(spi_sel), .tmr_sel(tmr_sel),
        .tref_m1(tref_m1), .sref_m1(sref_m1), .pwm_m1(pwm_m1), .bus_m1(bus_m1),
        .spi_m1(spi_m1), .uart_m1(uart_m1), .tmr_m1(tmr_m1)
    );

    clkpre_change_det #(.N_TMR(N_TMR)) u_chg (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .tmr_alt(tmr_alt),
        .spi_sel(spi_sel), .tmr_sel(tmr_sel),
        .clr_all(clr_all), .clr_tref(clr_tref), .clr_spi(clr_spi), .clr_tmr(clr_tmr)
    );

    // Root dividers count core cycles.
    clkpre_strobe_div #(.CNT_W(CNT_W)) u_tref (
        .clk(clk), .rst_n(rst_n), .en(1'b1), .clr(clr_tref),
        .ratio_m1(tref_m1), .stb(tmr_ref_stb));
    clkpre_strobe_div #(.CNT_W(CNT_W)) u_sref (
        .clk(clk), .rst_n(rst_n), .en(1'b1), .clr(clr_all),
        .ratio_m1(sref_m1), .stb(spi_ref_stb));
    clkpre_strobe_div #(.CNT_W(CNT_W)) u_pwm (
        .clk(clk), .rst_n(rst_n), .en(1'b1), .clr(clr_all),
        .ratio_m1(pwm_m1), .stb(pwm_stb));
    clkpre_strobe_div #(.CNT_W(CNT_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .en(1'b1), .clr(clr_all),
        .ratio_m1(bus_m1), .stb(bus_stb));

    // Child dividers count their parent's strobes.
    clkpre_strobe_div #(.CNT_W(CNT_W)) u_spi (
        .clk(clk), .rst_n(rst_n), .en(spi_ref_stb), .clr(clr_spi),
        .ratio_m1(spi_m1), .stb(spi_stb));
    clkpre_strobe_div #(.CNT_W(CNT_W)) u_uart (
        .clk(clk), .rst_n(rst_n), .en(bus_stb), .clr(clr_all),
        .ratio_m1(uart_m1), .stb(uart_stb));

    for (genvar gi = 0; gi < N_TMR; gi++) begin : g_tmr
        clkpre_strobe_div #(.CNT_W(CNT_W)) u_tmr (
            .clk(clk), .rst_n(rst_n), .en(tmr_ref_stb), .clr(clr_tmr[gi]),
            .ratio_m1(tmr_m1[gi]), .stb(tmr_stb[gi]));

        // R6: a timer child only fires together with the timer reference.
        assert_tmr_child_in_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_stb[gi] |-> tmr_ref_stb);
    end

    // R5: the serial child only fires together with its reference.
    assert_spi_child_in_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_stb |-> spi_ref_stb);

    // R7: UART strobe only fires together with a bus strobe.
    assert_uart_in_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        uart_stb |-> bus_stb);

    // R8: every strobe is quiet in the cycle a mode change is seen.
    assert_mode_change_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode != $past(ext_mode)) |->
        !(tmr_ref_stb || spi_ref_stb || pwm_stb || bus_stb || spi_stb || uart_stb || (|tmr_stb)));

    // R9: divide-by-1 serial child tracks its parent.
    assert_div1_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sel == 2'd3 && $stable(spi_sel)) |-> (spi_stb == spi_ref_stb));

    // R10: no strobe leaves the block while reset is held.
    always_comb begin
        if (!rst_n) begin
            assert_reset_quiet_R10: assert (!(tmr_ref_stb || spi_ref_stb || pwm_stb ||
                bus_stb || spi_stb || uart_stb || (|tmr_stb)));
        end
    end

endmodule

// File: tb/clkpre_prescaler_tb.sv
`timescale 1ns/1ps
module clkpre_prescaler_tb;

    localparam int NSIG = 8;
    localparam int I_TREF = 0, I_SREF = 1, I_PWM = 2, I_BUS = 3,
                   I_SPI = 4, I_TMR0 = 5, I_TMR1 = 6, I_UART = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_mode = 1'b0;
    logic       tmr_alt = 1'b0;
    logic [1:0] spi_sel = 2'd3;
    logic [1:0] tmr_sel = 2'b11;
    logic       tmr_ref_stb, spi_ref_stb, pwm_stb, bus_stb, spi_stb, uart_stb;
    logic [1:0] tmr_stb;
    logic [NSIG-1:0] sv;

    int nchk = 0, nfail = 0;
    int cyc = 0, mark = 0;
    int pcnt [NSIG];
    int lastc [NSIG];
    int per [NSIG];
    int firstc [NSIG];
    int div1_err = 0, b2b_err = 0;
    logic [2:0] prev_root = 3'b000;
    bit done = 1'b0;

    clkpre_prescaler u_dut (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .tmr_alt(tmr_alt),
        .spi_sel(spi_sel), .tmr_sel(tmr_sel),
        .tmr_ref_stb(tmr_ref_stb), .spi_ref_stb(spi_ref_stb), .pwm_stb(pwm_stb),
        .bus_stb(bus_stb), .spi_stb(spi_stb), .tmr_stb(tmr_stb), .uart_stb(uart_stb)
    );

    always #2.5 clk = ~clk;

    assign sv = {uart_stb, tmr_stb[1], tmr_stb[0], spi_stb, bus_stb, pwm_stb, spi_ref_stb, tmr_ref_stb};

    always @(posedge clk) cyc <= cyc + 1;

    // Pulse bookkeeping at the falling edge, away from the active edge.
    always @(negedge clk) begin
        for (int i = 0; i < NSIG; i++) begin
            if (sv[i]) begin
                if (pcnt[i] > 0) per[i] = cyc - lastc[i];
                lastc[i] = cyc;
                if (firstc[i] < 0) firstc[i] = cyc - mark;
                pcnt[i] = pcnt[i] + 1;
            end
        end
        if (rst_n) begin
            if (spi_sel == 2'd3 && spi_stb != spi_ref_stb) div1_err++;
            if (|(prev_root & {pwm_stb, spi_ref_stb, tmr_ref_stb})) b2b_err++;
        end
        prev_root = {pwm_stb, spi_ref_stb, tmr_ref_stb};
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic restart_track();
        for (int i = 0; i < NSIG; i++) begin
            pcnt[i] = 0;
            firstc[i] = -1;
            per[i] = -1;
        end
        mark = cyc;
    endtask

    task automatic wait_pulses(input int idx, input int n);
        int guard = 0;
        while (pcnt[idx] < n && guard < 20000) begin
            @(posedge clk);
            guard++;
        end
    endtask

    task automatic check_period(input int idx, input int exp, input string req, input string what);
        wait_pulses(idx, 2);
        check_eq(req, what, per[idx], exp);
    endtask

    task automatic check_first(input int idx, input int exp, input string req, input string what);
        wait_pulses(idx, 1);
        check_eq(req, what, firstc[idx], exp);
    endtask

    // R10: reset state and release latency.
    task automatic t_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_eq("R10", "strobes in reset", int'(sv), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        restart_track();
        check_first(I_BUS, 1, "R10", "bus first after release");
        check_first(I_TREF, 143, "R10", "timer ref first after release");
    endtask

    // R2, R7, R6, R9: PLL case rates.
    task automatic t_pll_rates();
        check_period(I_TREF, 144, "R2", "pll timer ref period");
        check_period(I_SREF, 576, "R2", "pll serial ref period");
        check_period(I_PWM, 768, "R2", "pll pwm period");
        check_period(I_BUS, 2, "R2", "pll bus period");
        check_period(I_UART, 20, "R7", "pll uart period");
        check_period(I_TMR0, 144, "R6", "pll timer0 div1 period");
        check_period(I_SPI, 576, "R9", "pll serial div1 period");
    endtask

    // R4: alt select ignored in PLL case, phase kept.
    task automatic t_pll_alt_ignored();
        int n = pcnt[I_TREF];
        while (pcnt[I_TREF] == n) @(posedge clk);
        #1;
        tmr_alt = 1'b1;
        restart_track();
        check_first(I_TREF, 143, "R4", "pll timer ref phase after alt toggle");
        check_period(I_TREF, 144, "R4", "pll timer ref period with alt");
        @(posedge clk); #1;
        tmr_alt = 1'b0;
    endtask

    // R8, R3, R7: switch to external case.
    task automatic t_ext_rates();
        @(posedge clk); #1;
        ext_mode = 1'b1;
        restart_track();
        @(negedge clk);
        check_eq("R8", "strobes in mode change cycle", int'(sv), 0);
        check_first(I_BUS, 1, "R8", "bus first after mode change");
        check_first(I_TREF, 24, "R8", "timer ref first after mode change");
        check_period(I_SREF, 96, "R3", "ext serial ref period");
        check_period(I_PWM, 128, "R3", "ext pwm period");
        check_period(I_BUS, 1, "R3", "ext bus period");
        check_period(I_UART, 10, "R7", "ext uart period");
        check_period(I_TREF, 24, "R4", "ext timer ref period alt=0");
    endtask

    // R4, R8: alt select in external case.
    task automatic t_ext_alt();
        @(posedge clk); #1;
        tmr_alt = 1'b1;
        restart_track();
        check_first(I_TREF, 26, "R8", "timer ref first after alt change");
        check_period(I_TREF, 26, "R4", "ext timer ref period alt=1");
        @(posedge clk); #1;
        tmr_alt = 1'b0;
        restart_track();
        check_period(I_TREF, 24, "R4", "ext timer ref period back to alt=0");
    endtask

    // R5: serial child code table.
    task automatic t_spi_codes();
        int divs [4] = '{32, 8, 2, 1};
        for (int c = 3; c >= 0; c--) begin
            @(posedge clk); #1;
            spi_sel = 2'(c);
            restart_track();
            check_period(I_SPI, 96 * divs[c], "R5", $sformatf("serial child code %0d", c));
        end
        @(posedge clk); #1;
        spi_sel = 2'd3;
    endtask

    // R6: timer child codes, independent per timer.
    task automatic t_tmr_codes();
        @(posedge clk); #1;
        tmr_sel = 2'b01;
        restart_track();
        check_period(I_TMR0, 24, "R6", "timer0 code 1");
        check_period(I_TMR1, 6144, "R6", "timer1 code 0");
        @(posedge clk); #1;
        tmr_sel = 2'b10;
        restart_track();
        check_period(I_TMR1, 24, "R6", "timer1 code 1");
        check_period(I_TMR0, 6144, "R6", "timer0 code 0");
    endtask

    initial begin
        restart_track();
        t_reset();
        t_pll_rates();
        t_pll_alt_ignored();
        t_ext_rates();
        t_ext_alt();
        t_spi_codes();
        t_tmr_codes();
        check_eq("R9", "divide-by-1 mismatch cycles", div1_err, 0);
        check_eq("R1", "back-to-back root strobes", b2b_err, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule